// File: doc/BRIEF.md
# Excluding Random Allocation Tag Generator

This block picks a 4-bit allocation tag for a pointer. In random mode it advances a 16-bit shift-register seed by four steps, gathers the four feedback bits into an offset, and then walks forward from a caller-supplied start tag. Each move of the walk lands on the next tag value that is not forbidden, and the walk makes as many moves as the offset says. Forbidden values come from two 16-bit masks: one supplied with the request and one from configuration. The block returns the chosen tag, the pointer with its tag field replaced, and a 24-bit state word. The state word packs the new tag and the advanced seed, so the caller can feed it back as the next start tag and seed.

In add mode the start tag is read from the pointer's own tag field. The offset comes from an explicit 4-bit operand, and only the configuration mask applies. A zero seed can be replaced by an entropy word before stepping. Each search tests one candidate per clock, and a single-cycle done pulse marks the result. Requests that arrive while a search is running are dropped.

Top module: `alloc_tag_gen`

## Requirements
- R1: In random mode, tag value i is forbidden when bit i of `req_excl` or bit i of `cfg_excl` is 1 (the OR of both masks).
- R2: When the mask in force has all 16 bits set, the result tag is 0 regardless of start tag and offset.
- R3: With an offset of zero, the result is the first tag value at or after the start tag, counting upward modulo 16, that is not forbidden.
- R4: With an offset N greater than zero, the result is reached from the start tag by N moves. Each move goes upward modulo 16 to the next tag value that is not forbidden.
- R5: One shift-register step computes feedback f = s[5]^s[3]^s[2]^s[0] and sets s to {f, s[15:1]}. Four steps run per random request, and the feedback of step k (k = 0..3) is bit k of the offset.
- R6: After a random request, `state_out[3:0]` holds the new tag, `state_out[23:8]` holds the seed after four steps, and `state_out[7:4]` is 0.
- R7: If `req_seed` is 0 and `cfg_reseed` is 1, then `entropy` is used as the seed when it is nonzero, and the constant 1 is used when it is zero. In every other case `req_seed` is used unchanged.
- R8: In add mode (`req_add_mode`=1), the start tag is `req_ptr[59:56]`, the offset is `req_offset`, and only `cfg_excl` applies. `req_excl`, `req_start_tag` and `req_seed` have no effect, and `state_out` keeps its value.
- R9: `ptr_out` equals `req_ptr` with bits [59:56] replaced by the chosen tag.
- R10: `done` is high for exactly one cycle per accepted request. It rises no later than 16*(N+1)+2 clock edges after the edge that accepts the request, where N is the offset.
- R11: A `req_valid` that arrives while a request is still in progress is ignored. It produces no second `done` and changes no output.
- R12: A synchronous reset with `rst_n`=0 clears `done`, `tag_out`, `ptr_out` and `state_out` to 0 and cancels any search in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_add_mode | input | 1 | 0 = random mode, 1 = add mode |
| req_start_tag | input | 4 | Start tag for random mode |
| req_seed | input | 16 | Seed for random mode |
| req_excl | input | 16 | Per-request exclusion mask (random mode) |
| cfg_excl | input | 16 | Configuration exclusion mask |
| cfg_reseed | input | 1 | Allow replacing a zero seed |
| entropy | input | 16 | Replacement seed source |
| req_ptr | input | 64 | Pointer; tag field at [59:56] |
| req_offset | input | 4 | Explicit offset for add mode |
| done | output | 1 | One-cycle result pulse |
| tag_out | output | 4 | Chosen tag |
| ptr_out | output | 64 | Pointer with tag field replaced |
| state_out | output | 24 | New tag at [3:0], seed at [23:8] |

## Verification
A corrupted seed or an offset bit placed in the wrong position shows up as a different tag, and in `state_out[23:8]`, on the same `done` pulse as the request that caused it. A walker whose current value or remaining-move count is wrong either returns a forbidden tag or stops at the wrong permitted tag; the bench catches both at the pulse. A walker that never meets its stop condition shows up as a missing `done` once the latency bound has passed. A wrong busy indication shows up as an extra pulse or a changed state word after an overlapping strobe.

// File: rtl/atg_pkg.sv
// Shared definitions for the allocation tag generator.
// Assumes a 4-bit tag and a seed of at least six bits for the feedback taps.
package atg_pkg;
    typedef enum logic {
        MODE_RAND = 1'b0,
        MODE_ADD  = 1'b1
    } atg_mode_e;

    // Feedback tap positions of the seed register
    localparam int TAP_A = 5;
    localparam int TAP_B = 3;
    localparam int TAP_C = 2;
    localparam int TAP_D = 0;
endpackage

// File: rtl/atg_seed_select.sv
// Chooses the seed used by a random request.
// A zero seed is replaced only when reseeding is enabled. The replacement is
// the entropy word when it is nonzero and the constant 1 otherwise.
module atg_seed_select #(
    parameter int SEED_W = 16
) (
    input  logic [SEED_W-1:0] seed_in,
    input  logic              reseed_en,
    input  logic [SEED_W-1:0] entropy_in,
    output logic [SEED_W-1:0] seed_eff
);
    localparam logic [SEED_W-1:0] SEED_ONE = SEED_W'(1);

    // Pick between the request seed, the entropy word and the constant
    always_comb begin
        seed_eff = seed_in;
        if (seed_in == '0 && reseed_en) begin
            seed_eff = (entropy_in != '0) ? entropy_in : SEED_ONE;
        end
    end
endmodule

// File: rtl/atg_lfsr_offset.sv
// Unrolls STEPS right-shifting feedback steps of the seed register.
// The feedback of step k becomes offset bit k. Purely combinational.
module atg_lfsr_offset
    import atg_pkg::*;
#(
    parameter int SEED_W = 16,
    parameter int STEPS  = 4
) (
    input  logic [SEED_W-1:0] seed_in,
    output logic [STEPS-1:0]  offset,
    output logic [SEED_W-1:0] seed_next
);
    logic [SEED_W-1:0] chain [0:STEPS];
    logic [STEPS-1:0]  fb;

    assign chain[0] = seed_in;

    // One feedback step per generate iteration
    for (genvar k = 0; k < STEPS; k++) begin : g_step
        assign fb[k] = chain[k][TAP_A] ^ chain[k][TAP_B] ^
                       chain[k][TAP_C] ^ chain[k][TAP_D];
        assign chain[k+1] = {fb[k], chain[k][SEED_W-1:1]};
    end

    assign offset    = fb;
    assign seed_next = chain[STEPS];
endmodule

// File: rtl/atg_tag_walker.sv
// Iterative search for a tag that is not excluded, one candidate per clock.
// With a zero remaining count it stops on the first permitted value at or
// after the current one. Otherwise each increment that lands on a permitted
// value uses up one move. An all-ones mask gives tag 0 at once.
// Assumes start is pulsed only while busy and done are both low.
module atg_tag_walker #(
    parameter int TAG_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [TAG_W-1:0]   start_tag,
    input  logic [TAG_W-1:0]   offset,
    input  logic [(1<<TAG_W)-1:0] mask,
    output logic               busy,
    output logic               done,
    output logic [TAG_W-1:0]   tag
);
    localparam int NTAG = 1 << TAG_W;

    logic [NTAG-1:0]  mask_q;
    logic [TAG_W-1:0] cur_q;
    logic [TAG_W-1:0] rem_q;
    logic [TAG_W-1:0] nxt;
    logic             busy_q;
    logic             done_q;
    logic [TAG_W-1:0] tag_q;

    // Next candidate, wrapping modulo the tag range
    always_comb nxt = cur_q + 1'b1;

    // Load a search, step it, and flag its end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            cur_q  <= '0;
            rem_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            tag_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                mask_q <= mask;
                cur_q  <= start_tag;
                rem_q  <= offset;
                if (&mask) begin
                    tag_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                end
            end else if (busy_q) begin
                if (rem_q == '0) begin
                    if (!mask_q[cur_q]) begin
                        tag_q  <= cur_q;
                        done_q <= 1'b1;
                        busy_q <= 1'b0;
                    end else begin
                        cur_q <= nxt;
                    end
                end else begin
                    cur_q <= nxt;
                    if (!mask_q[nxt]) begin
                        rem_q <= rem_q - 1'b1;
                    end
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign tag  = tag_q;
endmodule

// File: rtl/alloc_tag_gen.sv
// Allocation tag generator top level.
// Accepts a request when idle and selects start tag, offset and mask by mode.
// Runs the tag walker and registers the tag, the rewritten pointer and the
// state word on a one-cycle done pulse. Requests seen while busy are dropped.
module alloc_tag_gen
    import atg_pkg::*;
#(
    parameter int TAG_W    = 4,
    parameter int SEED_W   = 16,
    parameter int SEED_LSB = 8,
    parameter int PTR_W    = 64,
    parameter int TAG_LSB  = 56
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_add_mode,
    input  logic [TAG_W-1:0]           req_start_tag,
    input  logic [SEED_W-1:0]          req_seed,
    input  logic [(1<<TAG_W)-1:0]      req_excl,
    input  logic [(1<<TAG_W)-1:0]      cfg_excl,
    input  logic                       cfg_reseed,
    input  logic [SEED_W-1:0]          entropy,
    input  logic [PTR_W-1:0]           req_ptr,
    input  logic [TAG_W-1:0]           req_offset,
    output logic                       done,
    output logic [TAG_W-1:0]           tag_out,
    output logic [PTR_W-1:0]           ptr_out,
    output logic [SEED_LSB+SEED_W-1:0] state_out
);
    localparam int MASK_W  = 1 << TAG_W;
    localparam int STATE_W = SEED_LSB + SEED_W;

    atg_mode_e          req_mode;
    logic               accept;
    logic               walk_busy_any;
    logic [SEED_W-1:0]  seed_eff;
    logic [SEED_W-1:0]  seed_adv;
    logic [TAG_W-1:0]   rnd_off;
    logic [TAG_W-1:0]   sel_start;
    logic [TAG_W-1:0]   sel_off;
    logic [MASK_W-1:0]  sel_mask;
    logic               w_busy;
    logic               w_done;
    logic [TAG_W-1:0]   w_tag;

    atg_mode_e          mode_q;
    logic [PTR_W-1:0]   ptr_q;
    logic [SEED_W-1:0]  seed_q;
    logic               done_q;
    logic [TAG_W-1:0]   tag_q;
    logic [PTR_W-1:0]   ptr_out_q;
    logic [STATE_W-1:0] state_q;
    logic [PTR_W-1:0]   ptr_new;
    logic [STATE_W-1:0] state_new;

    // Decode the mode and decide whether the strobe is taken
    always_comb begin
        req_mode      = req_add_mode ? MODE_ADD : MODE_RAND;
        walk_busy_any = w_busy | w_done;
        accept        = req_valid && !walk_busy_any;
    end

    atg_seed_select #(.SEED_W(SEED_W)) u_seed (
        .seed_in    (req_seed),
        .reseed_en  (cfg_reseed),
        .entropy_in (entropy),
        .seed_eff   (seed_eff)
    );

    atg_lfsr_offset #(.SEED_W(SEED_W), .STEPS(TAG_W)) u_lfsr (
        .seed_in   (seed_eff),
        .offset    (rnd_off),
        .seed_next (seed_adv)
    );

    // Mode-dependent start tag, offset and exclusion mask
    always_comb begin
        if (req_mode == MODE_ADD) begin
            sel_start = req_ptr[TAG_LSB +: TAG_W];
            sel_off   = req_offset;
            sel_mask  = cfg_excl;
        end else begin
            sel_start = req_start_tag;
            sel_off   = rnd_off;
            sel_mask  = req_excl | cfg_excl;
        end
    end

    atg_tag_walker #(.TAG_W(TAG_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .start_tag (sel_start),
        .offset    (sel_off),
        .mask      (sel_mask),
        .busy      (w_busy),
        .done      (w_done),
        .tag       (w_tag)
    );

    // Capture the request context the result stage needs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RAND;
            ptr_q  <= '0;
            seed_q <= '0;
        end else if (accept) begin
            mode_q <= req_mode;
            ptr_q  <= req_ptr;
            seed_q <= seed_adv;
        end
    end

    // Build the rewritten pointer and the packed state word
    always_comb begin
        ptr_new                     = ptr_q;
        ptr_new[TAG_LSB +: TAG_W]   = w_tag;
        state_new                   = '0;
        state_new[TAG_W-1:0]        = w_tag;
        state_new[SEED_LSB +: SEED_W] = seed_q;
    end

    // Register the result and pulse done once per finished search
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            tag_q     <= '0;
            ptr_out_q <= '0;
            state_q   <= '0;
        end else begin
            done_q <= w_done;
            if (w_done) begin
                tag_q     <= w_tag;
                ptr_out_q <= ptr_new;
                if (mode_q == MODE_RAND) begin
                    state_q <= state_new;
                end
            end
        end
    end

    assign done      = done_q;
    assign tag_out   = tag_q;
    assign ptr_out   = ptr_out_q;
    assign state_out = state_q;
endmodule

// File: rtl/alloc_tag_gen_chk.sv
// Property checker for alloc_tag_gen, attached by bind.
// It keeps its own copy of the mask and mode of each accepted request,
// taken from the ports, and checks results against them.
module alloc_tag_gen_chk #(
    parameter int TAG_W    = 4,
    parameter int SEED_W   = 16,
    parameter int SEED_LSB = 8,
    parameter int PTR_W    = 64,
    parameter int TAG_LSB  = 56
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_add_mode,
    input logic [(1<<TAG_W)-1:0]      req_excl,
    input logic [(1<<TAG_W)-1:0]      cfg_excl,
    input logic                       busy,
    input logic                       done,
    input logic [TAG_W-1:0]           tag_out,
    input logic [PTR_W-1:0]           ptr_out,
    input logic [SEED_LSB+SEED_W-1:0] state_out
);
    localparam int NTAG  = 1 << TAG_W;
    localparam int LIMIT = NTAG * (NTAG + 1) + 2;

    logic [NTAG-1:0] chk_mask;
    logic            chk_add;
    logic [15:0]     busy_cnt;
    logic            take;

    always_comb take = req_valid && !busy;

    // Shadow the mask and mode of the accepted request; time the search
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_mask <= '0;
            chk_add  <= 1'b0;
            busy_cnt <= '0;
        end else if (take) begin
            chk_mask <= req_add_mode ? cfg_excl : (req_excl | cfg_excl);
            chk_add  <= req_add_mode;
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 16'd1;
        end
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= 16'(LIMIT));

    assert_tag_permitted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(&chk_mask)) |-> !chk_mask[tag_out]);

    assert_all_excluded_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (&chk_mask)) |-> (tag_out == '0));

    assert_add_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chk_add) |-> (state_out == $past(state_out)));

    assert_state_gap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_out[SEED_LSB-1:TAG_W] == '0);

    assert_ptr_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ptr_out[TAG_LSB +: TAG_W] == tag_out));

    assert_reset_quiet_R12: assert property (@(posedge clk)
        !rst_n |=> !done);
endmodule

bind alloc_tag_gen alloc_tag_gen_chk #(
    .TAG_W(TAG_W), .SEED_W(SEED_W), .SEED_LSB(SEED_LSB),
    .PTR_W(PTR_W), .TAG_LSB(TAG_LSB)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_add_mode (req_add_mode),
    .req_excl     (req_excl),
    .cfg_excl     (cfg_excl),
    .busy         (walk_busy_any),
    .done         (done),
    .tag_out      (tag_out),
    .ptr_out      (ptr_out),
    .state_out    (state_out)
);

// File: tb/alloc_tag_gen_test.sv
`timescale 1ns/1ps
module alloc_tag_gen_test;
    typedef struct packed {
        logic        mode;
        logic [3:0]  start;
        logic [15:0] seed;
        logic [15:0] rex;
        logic [15:0] cex;
        logic        reseed;
        logic [15:0] ent;
        logic [3:0]  ptag;
        logic [3:0]  offs;   // add-mode operand, or expected random offset
        logic [3:0]  etag;
        logic [23:0] estate;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 4'h0, 16'h0001, 16'h0000, 16'h0000, 1'b0, 16'h0000, 4'h0, 4'h1, 4'h1, 24'h100001},
        '{1'b0, 4'h5, 16'h002D, 16'h0040, 16'h0000, 1'b0, 16'h0000, 4'h3, 4'h2, 4'h8, 24'h200208},
        '{1'b0, 4'h3, 16'h0000, 16'h0000, 16'h0010, 1'b1, 16'h0000, 4'h0, 4'h1, 4'h5, 24'h100005},
        '{1'b0, 4'h7, 16'h0000, 16'h0080, 16'h0100, 1'b0, 16'h1234, 4'h0, 4'h0, 4'h9, 24'h000009},
        '{1'b0, 4'hE, 16'h0000, 16'h8000, 16'h0000, 1'b1, 16'h002D, 4'h0, 4'h2, 4'h1, 24'h200201},
        '{1'b0, 4'h6, 16'h0001, 16'hFF00, 16'h00FF, 1'b0, 16'h0000, 4'h0, 4'h1, 4'h0, 24'h100000},
        '{1'b0, 4'h9, 16'h0001, 16'h0000, 16'h0000, 1'b1, 16'h002D, 4'h0, 4'h1, 4'hA, 24'h10000A},
        '{1'b1, 4'h0, 16'h0000, 16'hFFFF, 16'h0800, 1'b0, 16'h0000, 4'hA, 4'h3, 4'hE, 24'h10000A},
        '{1'b1, 4'h0, 16'h0000, 16'h0000, 16'h0030, 1'b0, 16'h0000, 4'h4, 4'h0, 4'h6, 24'h10000A},
        '{1'b1, 4'h0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0000, 4'h0, 4'hF, 4'hF, 24'h10000A},
        '{1'b1, 4'h0, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 16'h0000, 4'h7, 4'h5, 4'h0, 24'h10000A},
        '{1'b1, 4'h0, 16'h0000, 16'h0000, 16'h0001, 1'b0, 16'h0000, 4'hF, 4'h2, 4'h2, 24'h10000A}
    };
    localparam logic [63:0] BASE = 64'h0123_4567_89AB_CDEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_add_mode = 1'b0;
    logic [3:0]  req_start_tag = '0;
    logic [15:0] req_seed = '0;
    logic [15:0] req_excl = '0;
    logic [15:0] cfg_excl = '0;
    logic        cfg_reseed = 1'b0;
    logic [15:0] entropy = '0;
    logic [63:0] req_ptr = '0;
    logic [3:0]  req_offset = '0;
    logic        done;
    logic [3:0]  tag_out;
    logic [63:0] ptr_out;
    logic [23:0] state_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    alloc_tag_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_add_mode(req_add_mode),
        .req_start_tag(req_start_tag), .req_seed(req_seed), .req_excl(req_excl),
        .cfg_excl(cfg_excl), .cfg_reseed(cfg_reseed), .entropy(entropy),
        .req_ptr(req_ptr), .req_offset(req_offset), .done(done), .tag_out(tag_out),
        .ptr_out(ptr_out), .state_out(state_out)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", what, act, exp);
        end
    endtask

    // Count edges until done; returns the count (capped)
    task automatic wait_done(output int n);
        n = 1;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int n;
        @(negedge clk);
        req_add_mode  = v.mode;
        req_start_tag = v.start;
        req_seed      = v.seed;
        req_excl      = v.rex;
        cfg_excl      = v.cex;
        cfg_reseed    = v.reseed;
        entropy       = v.ent;
        req_ptr       = {BASE[63:60], v.ptag, BASE[55:0]};
        req_offset    = v.mode ? v.offs : ~v.offs;
        req_valid     = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(n);
        $display("vector %0d", idx);
        chk("R10 done seen", {63'd0, done}, 64'd1);
        chk("R10 latency bound", {63'd0, (n <= 16 * (int'(v.offs) + 1) + 2)}, 64'd1);
        chk("R1/R2/R3/R4/R5/R7/R8 tag", {60'd0, tag_out}, {60'd0, v.etag});
        chk("R6/R7/R8 state", {40'd0, state_out}, {40'd0, v.estate});
        chk("R9 pointer", ptr_out, {BASE[63:60], v.etag, BASE[55:0]});
        @(negedge clk);
        chk("R10 single pulse", {63'd0, done}, 64'd0);
    endtask

    initial begin
        int n;
        int extra;
        repeat (3) @(negedge clk);
        // R12: reset values
        chk("R12 done after reset", {63'd0, done}, 64'd0);
        chk("R12 tag after reset", {60'd0, tag_out}, 64'd0);
        chk("R12 ptr after reset", ptr_out, 64'd0);
        chk("R12 state after reset", {40'd0, state_out}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R11: a strobe during a long search is dropped
        @(negedge clk);
        req_add_mode = 1'b1; cfg_excl = '0; req_offset = 4'hF;
        req_ptr = {BASE[63:60], 4'h0, BASE[55:0]};
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_add_mode = 1'b0; req_start_tag = 4'h2; req_seed = 16'h0001;
        req_excl = 16'h0000; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(n);
        chk("R11 first result tag", {60'd0, tag_out}, 64'hF);
        chk("R11 state untouched", {40'd0, state_out}, 64'h10000A);
        @(negedge clk);
        extra = 0;
        for (int k = 0; k < 40; k++) begin
            if (done) extra++;
            @(negedge clk);
        end
        chk("R11 no second done", 64'(extra), 64'd0);
        chk("R11 state after drop", {40'd0, state_out}, 64'h10000A);

        // R12: reset in the middle of a search cancels it
        req_add_mode = 1'b1; req_offset = 4'hF;
        req_ptr = {BASE[63:60], 4'h0, BASE[55:0]};
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R12 state cleared", {40'd0, state_out}, 64'd0);
        chk("R12 ptr cleared", ptr_out, 64'd0);
        extra = 0;
        for (int k = 0; k < 40; k++) begin
            if (done) extra++;
            @(negedge clk);
        end
        chk("R12 search cancelled", 64'(extra), 64'd0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule